// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns a 32-bit IEEE binary32 value into a 16-bit IEEE binary16 value, one conversion per clock, under a rounding mode chosen per operand. A valid strobe qualifies each operand. The result, with its own valid strobe, appears one clock later from a single output register. There is no back-pressure, so the block accepts a new operand on every cycle.

Each operand falls into one of six magnitude classes: not-a-number, infinity, overflow, normal, subnormal or underflow. Normal and subnormal operands share one alignment stage and one rounding incrementer. Overflow and nonzero underflow have fixed outcomes that depend on the rounding direction and the sign.

Top module: `sp2hp_cvt`

## Requirements
- R1: An input with an all-ones exponent and a nonzero fraction gives the quiet half NaN: magnitude 0x7E00, bit 15 equal to the input sign.
- R2: An input with an all-ones exponent and a zero fraction gives a half infinity: magnitude 0x7C00, bit 15 equal to the input sign.
- R3: A finite input with a biased exponent of 143 or more overflows. Mode 00 (nearest-even) gives magnitude 0x7C00. Mode 01 (toward zero) gives magnitude 0x7BFF.
- R4: On overflow in mode 10 (toward +inf), a positive input gives 0x7C00 and a negative input gives 0xFBFF. In mode 11 (toward -inf), a positive input gives 0x7BFF and a negative input gives 0xFC00.
- R5: An input with a biased exponent from 113 to 142 gives a normal half: the exponent is rebiased by -112 and the fraction is cut to its upper 10 bits. Rounding follows in_mode: nearest with ties to even, toward zero, toward +inf or toward -inf.
- R6: A rounding increment that carries out of the fraction raises the exponent. It can turn the largest subnormal into the smallest normal 0x0400, or a value near the top of the range into infinity 0x7C00.
- R7: An input with a biased exponent from 102 to 112 gives a subnormal (or, after a carry, the smallest normal) half. Its magnitude is the exact value in units of 2^-24, rounded under in_mode.
- R8: Smaller inputs, including binary32 subnormals and zero, give magnitude 0. The exception is a nonzero input that is positive in mode 10 or negative in mode 11: it gives magnitude 0x0001.
- R9: Output bit 15 always equals input bit 31, including for zero.
- R10: out_valid equals in_valid of the previous clock. Reset clears out_valid and out_data to zero.
- R11: In a cycle with in_valid low, out_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | binary32 operand |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | 16 | binary16 result |

## Verification
Rounding and a change of magnitude class can happen on the same operand. A carry from the rounding increment can move a subnormal into the normal range, or move the largest normal band into infinity, in the same cycle that selects the mode. The bench provokes this with operands just below 65536 and just below 2^-14, in every mode, plus random operands clustered around both exponent boundaries. It judges each result against an arithmetic reference that rounds the exact scaled value and then re-encodes it, without using class thresholds.

// File: rtl/hp_cvt_pkg.sv
package hp_cvt_pkg;

  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int SP_BIAS   = 127;
  localparam int HP_W      = 16;
  localparam int HP_EXP_W  = 5;
  localparam int HP_MAN_W  = 10;
  localparam int HP_BIAS   = 15;

  localparam int MAG_W     = SP_W - 1;
  localparam int HMAG_W    = HP_W - 1;
  localparam int SIG_W     = SP_MAN_W + 1;
  localparam int DROP_W    = SP_MAN_W - HP_MAN_W;
  localparam int REBIAS    = SP_BIAS - HP_BIAS - 0;
  localparam int NORM_MIN  = REBIAS + 1;
  localparam int OVF_MIN   = REBIAS + (1 << HP_EXP_W) - 1;
  localparam int SUB_MIN   = NORM_MIN - HP_MAN_W - 1;
  localparam int SUB_BASE  = SP_BIAS - 1;

  localparam logic [HMAG_W-1:0] HM_INF  = {{HP_EXP_W{1'b1}}, {HP_MAN_W{1'b0}}};
  localparam logic [HMAG_W-1:0] HM_QNAN = HM_INF | (HMAG_W'(1) << (HP_MAN_W - 1));
  localparam logic [HMAG_W-1:0] HM_MAXF = HM_INF - HMAG_W'(1);
  localparam logic [HMAG_W-1:0] HM_TINY = HMAG_W'(1);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rnd_mode_e;

  typedef enum logic [2:0] {
    MC_NAN  = 3'd0,
    MC_INF  = 3'd1,
    MC_OVF  = 3'd2,
    MC_NORM = 3'd3,
    MC_SUB  = 3'd4,
    MC_UNF  = 3'd5
  } mag_class_e;

  // True when the mode pushes this sign's magnitude away from zero.
  function automatic logic rounds_away(input rnd_mode_e mode, input logic sign);
    return ((mode == RM_UP) && !sign) || ((mode == RM_DOWN) && sign);
  endfunction

endpackage

// File: rtl/hp_cvt_classify.sv
module hp_cvt_classify
  import hp_cvt_pkg::*;
(
  input  logic [MAG_W-1:0] mag,
  output mag_class_e       cls
);
  logic [SP_EXP_W-1:0] exp_f;
  logic                frac_nz;

  assign exp_f   = mag[MAG_W-1 -: SP_EXP_W];
  assign frac_nz = |mag[SP_MAN_W-1:0];

  always_comb begin
    if (exp_f == {SP_EXP_W{1'b1}})        cls = frac_nz ? MC_NAN : MC_INF;
    else if (exp_f >= SP_EXP_W'(OVF_MIN)) cls = MC_OVF;
    else if (exp_f >= SP_EXP_W'(NORM_MIN)) cls = MC_NORM;
    else if (exp_f >= SP_EXP_W'(SUB_MIN)) cls = MC_SUB;
    else                                  cls = MC_UNF;
  end
endmodule

// File: rtl/hp_cvt_align.sv
module hp_cvt_align
  import hp_cvt_pkg::*;
(
  input  logic [MAG_W-1:0]  mag,
  input  logic              is_sub,
  output logic [HMAG_W-1:0] cand,
  output logic              guard,
  output logic              sticky
);
  logic [SP_EXP_W-1:0] exp_f;
  logic [HP_EXP_W-1:0] exp_h;
  logic [SIG_W-1:0]    sig;
  logic [SP_EXP_W-1:0] shamt;
  logic [SIG_W-1:0]    gmask;
  logic [HMAG_W-1:0]   cand_n;
  logic [HMAG_W-1:0]   cand_s;
  logic                g_n, s_n, g_s, s_s;

  assign exp_f = mag[MAG_W-1 -: SP_EXP_W];

  // Normal path: rebias exponent, keep upper fraction bits.
  assign exp_h  = mag[SP_MAN_W +: HP_EXP_W] - HP_EXP_W'(REBIAS);
  assign cand_n = {exp_h, mag[SP_MAN_W-1 -: HP_MAN_W]};
  assign g_n    = mag[DROP_W-1];
  assign s_n    = |mag[DROP_W-2:0];

  // Subnormal path: shift the full significand right.
  assign sig    = {1'b1, mag[SP_MAN_W-1:0]};
  assign shamt  = SP_EXP_W'(SUB_BASE) - exp_f;
  assign cand_s = HMAG_W'(sig >> shamt);
  assign gmask  = SIG_W'(1) << (shamt - SP_EXP_W'(1));
  assign g_s    = |(sig & gmask);
  assign s_s    = |(sig & (gmask - SIG_W'(1)));

  always_comb begin
    if (is_sub) begin
      cand   = cand_s;
      guard  = g_s;
      sticky = s_s;
    end else begin
      cand   = cand_n;
      guard  = g_n;
      sticky = s_n;
    end
  end
endmodule

// File: rtl/hp_cvt_round.sv
module hp_cvt_round
  import hp_cvt_pkg::*;
(
  input  logic [HMAG_W-1:0] cand,
  input  logic              guard,
  input  logic              sticky,
  input  logic              sign,
  input  rnd_mode_e         mode,
  output logic [HMAG_W-1:0] rounded
);
  logic inc;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = guard & (sticky | cand[0]);
      RM_ZERO: inc = 1'b0;
      default: inc = rounds_away(mode, sign) & (guard | sticky);
    endcase
  end

  // Carry out of the fraction lands in the exponent field.
  assign rounded = cand + HMAG_W'(inc);
endmodule

// File: rtl/sp2hp_cvt.sv
module sp2hp_cvt
  import hp_cvt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SP_W-1:0] in_data,
  input  logic [1:0]      in_mode,
  output logic            out_valid,
  output logic [HP_W-1:0] out_data
);
  logic              sign;
  logic [MAG_W-1:0]  mag;
  rnd_mode_e         mode;
  mag_class_e        cls;
  logic [HMAG_W-1:0] cand;
  logic              guard, sticky;
  logic [HMAG_W-1:0] rounded;
  logic [HMAG_W-1:0] res_mag;
  logic [HP_W-1:0]   data_d, data_q;
  logic              valid_d, valid_q;

  assign sign = in_data[SP_W-1];
  assign mag  = in_data[MAG_W-1:0];
  assign mode = rnd_mode_e'(in_mode);

  hp_cvt_classify u_cls (
    .mag (mag),
    .cls (cls)
  );

  hp_cvt_align u_aln (
    .mag    (mag),
    .is_sub (cls == MC_SUB),
    .cand   (cand),
    .guard  (guard),
    .sticky (sticky)
  );

  hp_cvt_round u_rnd (
    .cand    (cand),
    .guard   (guard),
    .sticky  (sticky),
    .sign    (sign),
    .mode    (mode),
    .rounded (rounded)
  );

  // Result selection per magnitude class.
  always_comb begin
    unique case (cls)
      MC_NAN:  res_mag = HM_QNAN;
      MC_INF:  res_mag = HM_INF;
      MC_OVF:  res_mag = ((mode == RM_NEAR) || rounds_away(mode, sign)) ? HM_INF : HM_MAXF;
      MC_NORM,
      MC_SUB:  res_mag = rounded;
      default: res_mag = ((|mag) && rounds_away(mode, sign)) ? HM_TINY : '0;
    endcase
  end

  // Next state with explicit clock enable on the data register.
  always_comb begin
    valid_d = in_valid;
    data_d  = in_valid ? {sign, res_mag} : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/hp_cvt_chk.sv
module hp_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic [1:0]  in_mode,
  input logic        out_valid,
  input logic [15:0] out_data
);
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (out_valid == $past(in_valid)));

  assert_sign_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(in_valid)) |-> (out_data[15] == $past(in_data[31])));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(in_valid)) |-> $stable(out_data));

  assert_nan_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(in_valid) && ($past(in_data[30:0]) > 31'h7F800000))
      |-> (out_data[14:0] == 15'h7E00));

  assert_rtz_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(in_valid) && ($past(in_mode) == 2'b01) &&
     ($past(in_data[30:0]) >= 31'h47800000) && ($past(in_data[30:0]) < 31'h7F800000))
      |-> (out_data[14:0] == 15'h7BFF));

  assert_zero_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(in_valid) && ($past(in_data[30:0]) == 31'h0))
      |-> (out_data[14:0] == 15'h0));

  assert_no_tiny_rtz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(in_valid) && ($past(in_mode) == 2'b01) &&
     ($past(in_data[30:0]) < 31'h33800000))
      |-> (out_data[14:0] == 15'h0));
endmodule

bind sp2hp_cvt hp_cvt_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sp2hp_cvt_tb_top.sv
`timescale 1ns/1ps
module sp2hp_cvt_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic [1:0]  in_mode;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [15:0] exp_data;

  sp2hp_cvt dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference: round the exact value, measured in units of 2^-24, then encode.
  function automatic logic [15:0] ref_half(logic [31:0] x, logic [1:0] m);
    logic s;
    int e, sh, msb, u, sft, p;
    longint unsigned mm, r, rem, half, v;
    bit inc, toward_small;
    s = x[31];
    e = int'(x[30:23]);
    toward_small = (m == 2'b01) || (m == 2'b10 && s) || (m == 2'b11 && !s);
    if (e == 255) return {s, (x[22:0] != 0) ? 15'h7E00 : 15'h7C00};
    if (e == 0) begin mm = longint'(x[22:0]); sh = -125; end
    else begin mm = longint'({1'b1, x[22:0]}); sh = e - 126; end
    if (mm == 0) return {s, 15'h0};
    msb = 0;
    for (int k = 0; k < 24; k++) if (mm[k]) msb = k;
    msb = msb + sh;
    if (msb >= 40) return {s, toward_small ? 15'h7BFF : 15'h7C00};
    u = (msb > 10) ? msb - 10 : 0;
    sft = u - sh;
    if (sft <= 0) begin r = mm << (-sft); rem = 0; half = 1; end
    else if (sft > 40) begin r = 0; rem = mm; half = 64'h8000_0000_0000_0000; end
    else begin r = mm >> sft; rem = mm & ((64'd1 << sft) - 1); half = 64'd1 << (sft - 1); end
    case (m)
      2'b00:   inc = (rem > half) || (rem == half && r[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = !s && (rem != 0);
      default: inc = s && (rem != 0);
    endcase
    v = (r + longint'(inc)) << u;
    if (v >= (64'd1 << 40)) return {s, toward_small ? 15'h7BFF : 15'h7C00};
    if (v < 1024) return {s, 15'(v)};
    p = 0;
    for (int k = 0; k < 41; k++) if (v[k]) p = k;
    return {s, 5'(p - 9), 10'((v >> (p - 10)) & 64'h3FF)};
  endfunction

  function automatic string ref_tag(logic [31:0] x, logic [1:0] m);
    int e;
    e = int'(x[30:23]);
    if (e == 255) return (x[22:0] != 0) ? "R1" : "R2";
    if (e >= 143) return (m[1] == 1'b0) ? "R3" : "R4";
    if (e >= 113) return "R5";
    if (e >= 102) return "R7";
    return "R8";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check its result at the next one.
  task automatic step(logic v, logic [31:0] x, logic [1:0] m, string tag);
    string t;
    @(negedge clk);
    in_valid = v; in_data = x; in_mode = m;
    t = tag;
    if (v) exp_data = ref_half(x, m);
    else   t = "R11";
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", 32'(out_valid), 32'(v));
    check(t, 32'(out_data), 32'(exp_data));
    if (v) check("R9", 32'(out_data[15]), 32'(x[31]));
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    int cls, e;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_mode = '0;
    exp_data = '0;
    repeat (3) @(negedge clk);
    check("R10", 32'(out_valid), 32'd0);
    check("R10", 32'(out_data), 32'd0);
    rst_n = 1'b1;

    // R5 normal conversions and ties
    step(1, 32'h3F800000, 2'b00, "R5");
    step(1, 32'h3F801000, 2'b00, "R5");
    step(1, 32'h3F803000, 2'b00, "R5");
    step(1, 32'h3F801001, 2'b01, "R5");
    step(1, 32'h3F801001, 2'b10, "R5");
    step(1, 32'hBF801001, 2'b11, "R5");
    step(1, 32'hBF801001, 2'b10, "R5");
    // R1 / R2 specials
    step(1, 32'h7FC00001, 2'b00, "R1");
    step(1, 32'hFF800001, 2'b10, "R1");
    step(1, 32'h7F800000, 2'b01, "R2");
    step(1, 32'hFF800000, 2'b00, "R2");
    // R3 / R4 overflow
    step(1, 32'h47800000, 2'b00, "R3");
    step(1, 32'h47800000, 2'b01, "R3");
    step(1, 32'hC7800000, 2'b01, "R3");
    step(1, 32'h47800000, 2'b10, "R4");
    step(1, 32'hC7800000, 2'b10, "R4");
    step(1, 32'h47800000, 2'b11, "R4");
    step(1, 32'hC7800000, 2'b11, "R4");
    // R6 carries into exponent
    step(1, 32'h477FF000, 2'b00, "R6");
    step(1, 32'h387FF000, 2'b00, "R6");
    step(1, 32'h477FE001, 2'b10, "R6");
    step(1, 32'h477FE001, 2'b01, "R6");
    step(1, 32'hB87FE001, 2'b11, "R6");
    // R7 subnormals
    step(1, 32'h33800000, 2'b00, "R7");
    step(1, 32'h38000000, 2'b00, "R7");
    step(1, 32'h33C00000, 2'b00, "R7");
    step(1, 32'h34200001, 2'b01, "R7");
    // R8 underflow
    step(1, 32'h33000000, 2'b00, "R8");
    step(1, 32'h33000000, 2'b10, "R8");
    step(1, 32'h00000001, 2'b11, "R8");
    step(1, 32'h80000001, 2'b11, "R8");
    step(1, 32'h80000001, 2'b10, "R8");
    // R9 signed zero
    step(1, 32'h80000000, 2'b00, "R9");
    step(1, 32'h00000000, 2'b10, "R9");
    // R11 idle cycles hold the last result
    step(1, 32'h40490FDB, 2'b00, "R5");
    step(0, 32'h3F800000, 2'b00, "R11");
    step(0, 32'h7FC00000, 2'b01, "R11");

    // Random operands clustered around the class boundaries
    for (int n = 0; n < 4000; n++) begin
      x = $urandom;
      cls = $urandom_range(0, 5);
      case (cls)
        0: e = $urandom_range(99, 115);
        1: e = $urandom_range(138, 146);
        2: e = ($urandom_range(0, 1) != 0) ? 255 : 0;
        default: e = int'(x[30:23]);
      endcase
      x[30:23] = 8'(e);
      step($urandom_range(0, 9) != 0, x, 2'($urandom_range(0, 3)), ref_tag(x, in_mode));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule